// File: doc/BRIEF.md
# Scanline and Cycle Interrupt Counter

This block is the interrupt counter of a cartridge memory mapper. It runs an 8-bit down-counter from one of two sources. In scanline mode the source is the video chip's address line A12, and a filter passes only one rising edge per rendered line. In cycle mode the source is the CPU's M2 clock divided by four. When the counter reaches zero while interrupts are enabled, the active-low interrupt output goes low and stays low until software acknowledges it.

Software sees four write strobes, each already decoded from the address bus, and the 8-bit data bus:
- a port that holds the reload value;
- a port that selects the source and arms a reload;
- an acknowledge port that also disables interrupts;
- an enable port.

Everything runs on one fast system clock. M2 and A12 arrive as synchronous levels that the block samples on that clock.

Top module: `scanirq_counter`

## Requirements
- R1: After reset, irq_n is high and the count, reload value, enable and pending flags are all zero. Enabling and then giving one counter clock therefore loads zero and asserts the interrupt.
- R2: A write to the reload-value port stores all 8 data bits. A value of 255 gives exactly 256 counter clocks to the first interrupt.
- R3: A write to the source port arms a reload for the next counter clock. Data bit 0 selects the source: 1 selects cycle mode and 0 selects scanline mode.
- R4: In scanline mode, a rising edge of A12 counts only if A12 was low during at least 3 M2 rising edges just before it. An edge after 2 low M2 edges is ignored, and so is A12 held steady.
- R5: In cycle mode, one counter clock occurs on every 4th M2 rising edge, counted from the last write to the source port. A12 has no effect in this mode.
- R6: On each counter clock the count takes the reload value if it is zero or a reload is armed; otherwise it decrements. With reload value N, the first interrupt comes on counter clock N+1.
- R7: Once low, irq_n stays low across further counter clocks until the acknowledge port is written.
- R8: A write to the acknowledge port drives irq_n high and disables interrupts. While disabled, the count still reaches zero but irq_n stays high.
- R9: A write to the enable port, which may come several lines after the acknowledge, makes the next zero of the count assert irq_n.
- R10: Register writes never clock the counter. The interrupt timing is the same whether writes happen while A12 is held high or held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples M2 and A12 |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_data | input | 8 | CPU data bus value for the write strobes |
| wr_reload_val | input | 1 | Write strobe for the reload-value port |
| wr_src_reload | input | 1 | Write strobe for the source/reload-arm port |
| wr_ack | input | 1 | Write strobe that acknowledges and disables |
| wr_enable | input | 1 | Write strobe that enables interrupts |
| m2 | input | 1 | CPU M2 clock level |
| a12 | input | 1 | Video address line A12 level |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
On every cycle, the embedded assertions check the following:
- the interrupt latch holds until it is acknowledged;
- an acknowledge always clears the latch;
- the latch only rises while the count is zero and interrupts are enabled;
- an armed reload loads the stored value;
- a filtered A12 pulse only comes with A12 high;
- neither the filter nor the prescaler emits pulses back to back.

Only the bench scenarios can show the exact number of lines or M2 cycles before the interrupt. They also show that sprite-fetch A12 toggles and short-low edges are dropped, that the low-count boundary sits at exactly 3, and that writes made while A12 is held steady never clock the counter.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;
    typedef enum logic {
        SRC_SCANLINE = 1'b0,
        SRC_CYCLE    = 1'b1
    } src_e;
endpackage

// File: rtl/scanirq_a12_filter.sv
module scanirq_a12_filter #(
    parameter int LOW_MIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic m2_tick,
    input  logic a12,
    output logic line_tick
);
    localparam int LW = $clog2(LOW_MIN + 1);

    typedef struct packed {
        logic          a12;
        logic [LW-1:0] low_cnt;
        logic          pulse;
    } filt_t;

    filt_t q, d;

    always_comb begin
        d = q;
        d.a12 = a12;
        // a rising edge only counts after a long enough low stretch
        d.pulse = a12 && !q.a12 && (q.low_cnt >= LW'(LOW_MIN));
        if (a12) begin
            d.low_cnt = '0;
        end else if (m2_tick && (q.low_cnt < LW'(LOW_MIN))) begin
            d.low_cnt = q.low_cnt + LW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign line_tick = q.pulse;

    a_r4_pulse_with_high: assert property (@(posedge clk) disable iff (!rst_n)
        q.pulse |-> q.a12);
    a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.pulse |=> !q.pulse);
endmodule

// File: rtl/scanirq_prescaler.sv
module scanirq_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic m2_tick,
    output logic cyc_tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          tick;
    } pre_t;

    pre_t q, d;

    always_comb begin
        d = q;
        d.tick = 1'b0;
        if (clear) begin
            d.cnt = '0;
        end else if (m2_tick) begin
            if (q.cnt == PW'(DIV - 1)) begin
                d.cnt  = '0;
                d.tick = 1'b1;
            end else begin
                d.cnt = q.cnt + PW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cyc_tick = q.tick;

    a_r5_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        q.tick |=> !q.tick);
endmodule

// File: rtl/scanirq_core.sv
module scanirq_core
    import scanirq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] wdata,
    input  logic             wr_val,
    input  logic             wr_src,
    input  logic             wr_ack,
    input  logic             wr_en,
    input  logic             line_tick,
    input  logic             cyc_tick,
    output logic             irq
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] reload;
        logic             pend;
        logic             en;
        logic             irq;
        src_e             src;
    } core_t;

    core_t q, d;
    logic  tick;

    assign tick = (q.src == SRC_CYCLE) ? cyc_tick : line_tick;

    always_comb begin
        d = q;
        if (tick) begin
            if ((q.cnt == '0) || q.pend) begin
                d.cnt  = q.reload;
                d.pend = 1'b0;
            end else begin
                d.cnt = q.cnt - CNT_W'(1);
            end
            if ((d.cnt == '0) && q.en) d.irq = 1'b1;
        end
        // writes take precedence over a same-cycle counter clock
        if (wr_val) d.reload = wdata;
        if (wr_src) begin
            d.pend = 1'b1;
            d.src  = src_e'(wdata[0]);
        end
        if (wr_ack) begin
            d.irq = 1'b0;
            d.en  = 1'b0;
        end
        if (wr_en) d.en = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq = q.irq;

    a_r7_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.irq && !wr_ack) |=> q.irq);
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> !q.irq);
    a_r6_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.irq) |-> (q.cnt == '0));
    a_r9_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.irq) |-> $past(q.en));
    a_r3_armed_load: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pend && tick && !wr_src) |=> (q.cnt == $past(q.reload)));
endmodule

// File: rtl/scanirq_counter.sv
module scanirq_counter #(
    parameter int CNT_W   = 8,
    parameter int LOW_MIN = 3,
    parameter int DIV     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cpu_data,
    input  logic             wr_reload_val,
    input  logic             wr_src_reload,
    input  logic             wr_ack,
    input  logic             wr_enable,
    input  logic             m2,
    input  logic             a12,
    output logic             irq_n
);
    typedef struct packed {
        logic m2;
    } top_t;

    top_t q, d;
    logic m2_tick;
    logic line_tick;
    logic cyc_tick;
    logic irq;

    always_comb begin
        d = q;
        d.m2 = m2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign m2_tick = m2 && !q.m2;

    scanirq_a12_filter #(.LOW_MIN(LOW_MIN)) u_filter (
        .clk(clk), .rst_n(rst_n), .m2_tick(m2_tick), .a12(a12),
        .line_tick(line_tick)
    );

    scanirq_prescaler #(.DIV(DIV)) u_prescale (
        .clk(clk), .rst_n(rst_n), .clear(wr_src_reload), .m2_tick(m2_tick),
        .cyc_tick(cyc_tick)
    );

    scanirq_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .wdata(cpu_data),
        .wr_val(wr_reload_val), .wr_src(wr_src_reload),
        .wr_ack(wr_ack), .wr_en(wr_enable),
        .line_tick(line_tick), .cyc_tick(cyc_tick), .irq(irq)
    );

    assign irq_n = ~irq;
endmodule

// File: tb/scanirq_counter_tb.sv
module scanirq_counter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cpu_data = '0;
    logic       wr_reload_val = 1'b0;
    logic       wr_src_reload = 1'b0;
    logic       wr_ack = 1'b0;
    logic       wr_enable = 1'b0;
    logic       m2 = 1'b0;
    logic       a12 = 1'b0;
    logic       irq_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    scanirq_counter u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_data(cpu_data),
        .wr_reload_val(wr_reload_val), .wr_src_reload(wr_src_reload),
        .wr_ack(wr_ack), .wr_enable(wr_enable),
        .m2(m2), .a12(a12), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: irq_n=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // one M2 period: 2 clocks high, 2 low, A12 set at its start
    task automatic m2_cycle(input logic a);
        a12 = a;
        m2 = 1'b1;
        repeat (2) @(negedge clk);
        m2 = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(input int port, input logic [7:0] val);
        cpu_data = val;
        case (port)
            0: wr_reload_val = 1'b1;
            1: wr_src_reload = 1'b1;
            2: wr_ack = 1'b1;
            default: wr_enable = 1'b1;
        endcase
        @(negedge clk);
        wr_reload_val = 1'b0;
        wr_src_reload = 1'b0;
        wr_ack = 1'b0;
        wr_enable = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // a rendered line: long low stretch, then eight sprite-fetch toggles
    task automatic line();
        for (int i = 0; i < 10; i++) m2_cycle(1'b0);
        for (int i = 0; i < 8; i++) begin
            m2_cycle(1'b1);
            m2_cycle(1'b0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 reset irq_n high", irq_n, 1'b1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle after reset", irq_n, 1'b1);
        // reload value and count are zero: one clock loads zero
        wr(3, 8'h00);
        line();
        check("R1 cleared reload gives immediate zero", irq_n, 1'b0);
        wr(2, 8'h00);
        check("R8 ack clears irq", irq_n, 1'b1);

        // scanline sweep: IRQ on line N+1, then held until ack
        for (int n = 1; n <= 6; n++) begin
            wr(0, 8'(n));
            wr(1, 8'h00);
            wr(2, 8'h00);
            wr(3, 8'h00);
            for (int k = 1; k <= n + 1; k++) begin
                line();
                check("R6 R3 scanline count", irq_n, (k == n + 1) ? 1'b0 : 1'b1);
            end
            line();
            check("R7 irq held across clock", irq_n, 1'b0);
            wr(2, 8'h00);
            check("R8 ack releases irq", irq_n, 1'b1);
        end

        // A12 filter: reload 1 -> first valid edge loads, second reaches 0
        wr(0, 8'd1);
        wr(1, 8'h00);
        wr(2, 8'h00);
        wr(3, 8'h00);
        line();
        check("R4 first valid edge loads only", irq_n, 1'b1);
        for (int j = 0; j < 4; j++) begin
            m2_cycle(1'b1);
            m2_cycle(1'b0);
            m2_cycle(1'b0);
        end
        m2_cycle(1'b1);
        check("R4 edge after two lows ignored", irq_n, 1'b1);
        // R10: writes with A12 held high, then held low
        for (int j = 0; j < 5; j++) m2_cycle(1'b1);
        wr(0, 8'd1);
        wr(3, 8'h00);
        check("R10 writes with A12 high do not clock", irq_n, 1'b1);
        m2_cycle(1'b0);
        wr(0, 8'd1);
        wr(3, 8'h00);
        m2_cycle(1'b1);
        check("R10 writes with A12 low do not clock", irq_n, 1'b1);
        m2_cycle(1'b0);
        m2_cycle(1'b0);
        m2_cycle(1'b0);
        m2_cycle(1'b1);
        check("R4 edge after exactly three lows counts", irq_n, 1'b0);
        wr(2, 8'h00);

        // disabled zero crossing, then late enable
        wr(0, 8'd2);
        wr(1, 8'h00);
        for (int k = 0; k < 3; k++) line();
        check("R8 zero while disabled stays high", irq_n, 1'b1);
        wr(3, 8'h00);
        line();
        line();
        check("R9 not yet at zero", irq_n, 1'b1);
        line();
        check("R9 late enable asserts at next zero", irq_n, 1'b0);
        wr(2, 8'h00);

        // cycle mode sweep: IRQ after (N+1)*4 M2 cycles, A12 ignored
        for (int n = 0; n <= 3; n++) begin
            wr(0, 8'(n));
            wr(2, 8'h00);
            wr(3, 8'h00);
            wr(1, 8'h01);
            for (int k = 1; k <= (n + 1) * 4; k++) begin
                m2_cycle((k % 5) == 4);
                check("R5 cycle count with A12 ignored", irq_n,
                      (k == (n + 1) * 4) ? 1'b0 : 1'b1);
            end
            wr(2, 8'h00);
        end

        // full 8-bit reload value
        wr(0, 8'hFF);
        wr(2, 8'h00);
        wr(3, 8'h00);
        wr(1, 8'h01);
        for (int k = 1; k < 256 * 4; k++) m2_cycle(1'b0);
        check("R2 reload 255 not early", irq_n, 1'b1);
        m2_cycle(1'b0);
        check("R2 reload 255 fires on clock 256", irq_n, 1'b0);
        wr(2, 8'h00);
        check("R8 final ack", irq_n, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule